// File: doc/BRIEF.md
# Indexed Protection Region Register Bank

This block stores the configuration of a set of memory protection regions (sixteen by default) and delivers every region's settings in parallel to a separate permission checker. Software reaches the bank through a small register-access port. A two-bit select code names one of four register kinds. A write-data bus, a read-data bus and a privilege flag complete the port. The select code takes the place of instruction decoding, which is done elsewhere.

Each region's registers are not mapped flat. A region-number register names one region, and every later access to the base, size/enable or access-control register goes to that region's copy. Writes keep only the defined fields of each register. Reserved and should-be-zero bits always read back as zero. Any access made without privilege is refused. It raises an error flag in the same cycle, leaves all state unchanged and returns zero read data.

Top module: `prot_region_bank`

## Requirements
- R1: The region-number register (select code 0) holds a region index in bits [3:0]. A privileged write stores `wdata[3:0]`. A privileged read returns that index with bits [31:4] zero.
- R2: The select code is 0 for the region number, 1 for base, 2 for size/enable and 3 for access control. Accesses with codes 1 to 3 read or write only the copy that belongs to the region named by the current region index.
- R3: The base register keeps bits [31:5] of the written word. Bits [4:0] read back as 0.
- R4: The size/enable register keeps a 5-bit size code in bits [5:1] and the enable in bit [0]. Bits [31:6] read back as 0. A region's enable changes only after a privileged size/enable write.
- R5: The access-control register keeps execute-never in bit [12], access permission in bits [10:8], type extension in bits [5:3], and shareable, cacheable and bufferable in bits [2], [1], [0]. Bits [31:13], [11] and [7:6] read back as 0.
- R6: Reset clears every region's enable to 0, clears every stored field and sets the region index to 0.
- R7: An access with `acc_en_i`=1 and `acc_priv_i`=0 drives `acc_undef_o` high in the same cycle. It returns read data 0 and changes no state. A privileged access never raises `acc_undef_o`.
- R8: For each region i, the parallel outputs give the stored fields in these slices: base bits [31:5] at `rgn_base_o[i*27 +: 27]`, size code at `rgn_size_o[i*5 +: 5]`, enable at `rgn_en_o[i]`, access permission at `rgn_ap_o[i*3 +: 3]` and execute-never at `rgn_xn_o[i]`. Each output shows a new value in the cycle after the write that sets it, and a single write changes at most one region's enable.
- R9: Read data is combinational in the cycle of a privileged read. It is 0 whenever `acc_en_i` is low or the access is a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| acc_en_i | input | 1 | Register access valid this cycle |
| acc_wr_i | input | 1 | 1 = write, 0 = read |
| acc_priv_i | input | 1 | 1 = privileged access |
| acc_sel_i | input | 2 | Register kind: 0 number, 1 base, 2 size/enable, 3 access control |
| acc_wdata_i | input | 32 | Write data |
| acc_rdata_o | output | 32 | Read data, valid in the cycle of the read |
| acc_undef_o | output | 1 | Unprivileged access refused |
| rgn_base_o | output | NUM_REGIONS*27 | Base address bits [31:5] of each region |
| rgn_size_o | output | NUM_REGIONS*5 | Size code of each region |
| rgn_en_o | output | NUM_REGIONS | Enable of each region |
| rgn_ap_o | output | NUM_REGIONS*3 | Access permission of each region |
| rgn_xn_o | output | NUM_REGIONS | Execute-never of each region |

## Verification
The assertions assume that the access inputs are known and steady around each rising edge. They also assume at most one access per cycle, with the select code always one of the four defined values. The stimulus meets these assumptions. It drives every access on the falling edge, holds it through one rising edge and then drops `acc_en_i`. The sweep covers every region with patterns that set all reserved bits. It repeats unprivileged writes and reads of every register kind while a region is selected, and it applies reset a second time partway through the run.

// File: rtl/prb_pkg.sv
package prb_pkg;
  localparam int DW      = 32;
  localparam int BASE_LSB = 5;
  localparam int BASE_W  = DW - BASE_LSB;
  localparam int SIZE_W  = 5;
  localparam int AP_W    = 3;
  localparam int TEX_W   = 3;

  typedef enum logic [1:0] {
    SEL_RNUM = 2'd0,
    SEL_BASE = 2'd1,
    SEL_SIZE = 2'd2,
    SEL_ACL  = 2'd3
  } sel_e;

  typedef struct packed {
    logic             xn;
    logic [AP_W-1:0]  ap;
    logic [TEX_W-1:0] tex;
    logic             s;
    logic             c;
    logic             b;
  } acl_t;

  function automatic logic [DW-1:0] base_word(input logic [BASE_W-1:0] base);
    return {base, {BASE_LSB{1'b0}}};
  endfunction

  function automatic logic [DW-1:0] size_word(input logic [SIZE_W-1:0] code, input logic en);
    return {{(DW-SIZE_W-1){1'b0}}, code, en};
  endfunction

  function automatic logic [DW-1:0] acl_word(input acl_t a);
    return {19'd0, a.xn, 1'b0, a.ap, 2'b00, a.tex, a.s, a.c, a.b};
  endfunction

  function automatic acl_t acl_take(input logic [DW-1:0] w);
    acl_t a;
    a.xn  = w[12];
    a.ap  = w[10:8];
    a.tex = w[5:3];
    a.s   = w[2];
    a.c   = w[1];
    a.b   = w[0];
    return a;
  endfunction
endpackage

// File: rtl/prb_index_reg.sv
module prb_index_reg #(
  parameter int IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [IDX_W-1:0] wdata_i,
  output logic [IDX_W-1:0] idx_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   idx_o <= '0;
    else if (wr_i) idx_o <= wdata_i;
  end
endmodule

// File: rtl/prb_region_slot.sv
module prb_region_slot
  import prb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_base_i,
  input  logic              wr_size_i,
  input  logic              wr_acl_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [BASE_W-1:0] base_o,
  output logic [SIZE_W-1:0] size_o,
  output logic              en_o,
  output acl_t              acl_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_o <= '0;
      size_o <= '0;
      en_o   <= 1'b0;
      acl_o  <= '0;
    end else begin
      if (wr_base_i) base_o <= wdata_i[DW-1:BASE_LSB];
      if (wr_size_i) begin
        size_o <= wdata_i[SIZE_W:1];
        en_o   <= wdata_i[0];
      end
      if (wr_acl_i) acl_o <= acl_take(wdata_i);
    end
  end
endmodule

// File: rtl/prb_read_mux.sv
module prb_read_mux
  import prb_pkg::*;
#(
  parameter int NUM_REGIONS = 16,
  parameter int IDX_W       = 4
) (
  input  logic             rd_fire_i,
  input  sel_e             sel_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [NUM_REGIONS-1:0] hit_i,
  input  logic [DW-1:0]    base_w_i [NUM_REGIONS],
  input  logic [DW-1:0]    size_w_i [NUM_REGIONS],
  input  logic [DW-1:0]    acl_w_i  [NUM_REGIONS],
  output logic [DW-1:0]    rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (rd_fire_i) begin
      case (sel_i)
        SEL_RNUM: rdata_o = DW'(idx_i);
        SEL_BASE: for (int i = 0; i < NUM_REGIONS; i++) if (hit_i[i]) rdata_o = base_w_i[i];
        SEL_SIZE: for (int i = 0; i < NUM_REGIONS; i++) if (hit_i[i]) rdata_o = size_w_i[i];
        default:  for (int i = 0; i < NUM_REGIONS; i++) if (hit_i[i]) rdata_o = acl_w_i[i];
      endcase
    end
  end
endmodule

// File: rtl/prot_region_bank.sv
module prot_region_bank
  import prb_pkg::*;
#(
  parameter int NUM_REGIONS = 16
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          acc_en_i,
  input  logic                          acc_wr_i,
  input  logic                          acc_priv_i,
  input  logic [1:0]                    acc_sel_i,
  input  logic [31:0]                   acc_wdata_i,
  output logic [31:0]                   acc_rdata_o,
  output logic                          acc_undef_o,
  output logic [NUM_REGIONS*27-1:0]     rgn_base_o,
  output logic [NUM_REGIONS*5-1:0]      rgn_size_o,
  output logic [NUM_REGIONS-1:0]        rgn_en_o,
  output logic [NUM_REGIONS*3-1:0]      rgn_ap_o,
  output logic [NUM_REGIONS-1:0]        rgn_xn_o
);
  localparam int IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;

  sel_e             sel;
  logic             acc_ok;
  logic             wr_fire;
  logic             rd_fire;
  logic [IDX_W-1:0] cur_idx;
  logic [NUM_REGIONS-1:0] sel_hit;
  logic [DW-1:0]    base_w [NUM_REGIONS];
  logic [DW-1:0]    size_w [NUM_REGIONS];
  logic [DW-1:0]    acl_w  [NUM_REGIONS];

  assign sel         = sel_e'(acc_sel_i);
  assign acc_ok      = acc_en_i & acc_priv_i;
  assign acc_undef_o = acc_en_i & ~acc_priv_i;
  assign wr_fire     = acc_ok & acc_wr_i;
  assign rd_fire     = acc_ok & ~acc_wr_i;

  prb_index_reg #(.IDX_W(IDX_W)) u_idx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_fire && sel == SEL_RNUM),
    .wdata_i (acc_wdata_i[IDX_W-1:0]),
    .idx_o   (cur_idx)
  );

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_rgn
    logic [BASE_W-1:0] base_q;
    logic [SIZE_W-1:0] size_q;
    logic              en_q;
    acl_t              acl_q;

    assign sel_hit[g] = (cur_idx == IDX_W'(g));

    prb_region_slot u_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_base_i (wr_fire && sel_hit[g] && sel == SEL_BASE),
      .wr_size_i (wr_fire && sel_hit[g] && sel == SEL_SIZE),
      .wr_acl_i  (wr_fire && sel_hit[g] && sel == SEL_ACL),
      .wdata_i   (acc_wdata_i),
      .base_o    (base_q),
      .size_o    (size_q),
      .en_o      (en_q),
      .acl_o     (acl_q)
    );

    assign base_w[g] = base_word(base_q);
    assign size_w[g] = size_word(size_q, en_q);
    assign acl_w[g]  = acl_word(acl_q);

    assign rgn_base_o[g*BASE_W +: BASE_W] = base_q;
    assign rgn_size_o[g*SIZE_W +: SIZE_W] = size_q;
    assign rgn_en_o[g]                    = en_q;
    assign rgn_ap_o[g*AP_W +: AP_W]       = acl_q.ap;
    assign rgn_xn_o[g]                    = acl_q.xn;
  end

  prb_read_mux #(.NUM_REGIONS(NUM_REGIONS), .IDX_W(IDX_W)) u_rmux (
    .rd_fire_i (rd_fire),
    .sel_i     (sel),
    .idx_i     (cur_idx),
    .hit_i     (sel_hit),
    .base_w_i  (base_w),
    .size_w_i  (size_w),
    .acl_w_i   (acl_w),
    .rdata_o   (acc_rdata_o)
  );
endmodule

// File: rtl/prb_checker.sv
module prb_checker #(
  parameter int NUM_REGIONS = 16,
  parameter int IDX_W       = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      acc_en,
  input logic                      acc_wr,
  input logic                      acc_priv,
  input logic [1:0]                acc_sel,
  input logic [31:0]               acc_rdata,
  input logic                      acc_undef,
  input logic [NUM_REGIONS*27-1:0] rgn_base,
  input logic [NUM_REGIONS*5-1:0]  rgn_size,
  input logic [NUM_REGIONS-1:0]    rgn_en,
  input logic [NUM_REGIONS*3-1:0]  rgn_ap,
  input logic [NUM_REGIONS-1:0]    rgn_xn,
  input logic [IDX_W-1:0]          cur_idx
);
  AST_USER_NO_STATE_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_priv) |=> ($stable(rgn_base) && $stable(rgn_size) && $stable(rgn_en)
                               && $stable(rgn_ap) && $stable(rgn_xn) && $stable(cur_idx))); // R7
  AST_USER_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_priv) |-> (acc_undef && acc_rdata == 32'd0)); // R7
  AST_PRIV_NO_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
    acc_priv |-> !acc_undef); // R7
  AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_en || acc_wr) |-> acc_rdata == 32'd0); // R9
  AST_RNUM_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_wr && acc_sel == 2'd0) |-> acc_rdata[31:4] == 28'd0); // R1
  AST_BASE_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_wr && acc_sel == 2'd1) |-> acc_rdata[4:0] == 5'd0); // R3
  AST_SIZE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_wr && acc_sel == 2'd2) |-> acc_rdata[31:6] == 26'd0); // R4
  AST_ACL_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_wr && acc_sel == 2'd3) |-> (acc_rdata & ~32'h0000_173F) == 32'd0); // R5
  AST_EN_NEEDS_SIZE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rgn_en) |-> $past(acc_en && acc_wr && acc_priv && acc_sel == 2'd2)); // R4
  AST_ONE_EN_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rgn_en ^ $past(rgn_en))); // R8
  AST_RESET_ALL_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (rgn_en == '0 && cur_idx == '0)); // R6
endmodule

bind prot_region_bank prb_checker #(.NUM_REGIONS(NUM_REGIONS), .IDX_W(IDX_W)) u_chk (
  .clk       (clk_i),
  .rst_n     (rst_ni),
  .acc_en    (acc_en_i),
  .acc_wr    (acc_wr_i),
  .acc_priv  (acc_priv_i),
  .acc_sel   (acc_sel_i),
  .acc_rdata (acc_rdata_o),
  .acc_undef (acc_undef_o),
  .rgn_base  (rgn_base_o),
  .rgn_size  (rgn_size_o),
  .rgn_en    (rgn_en_o),
  .rgn_ap    (rgn_ap_o),
  .rgn_xn    (rgn_xn_o),
  .cur_idx   (cur_idx)
);

// File: tb/sim_prot_region_bank.sv
module sim_prot_region_bank;
  localparam int N = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_en = 1'b0, acc_wr = 1'b0, acc_priv = 1'b0;
  logic [1:0]  acc_sel = 2'd0;
  logic [31:0] acc_wdata = 32'd0;
  logic [31:0] acc_rdata;
  logic        acc_undef;
  logic [N*27-1:0] rgn_base;
  logic [N*5-1:0]  rgn_size;
  logic [N-1:0]    rgn_en;
  logic [N*3-1:0]  rgn_ap;
  logic [N-1:0]    rgn_xn;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] exp_base [N];
  logic [31:0] exp_size [N];
  logic [31:0] exp_acl  [N];

  always #2.5 clk = ~clk;

  prot_region_bank #(.NUM_REGIONS(N)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .acc_en_i(acc_en), .acc_wr_i(acc_wr),
    .acc_priv_i(acc_priv), .acc_sel_i(acc_sel), .acc_wdata_i(acc_wdata),
    .acc_rdata_o(acc_rdata), .acc_undef_o(acc_undef), .rgn_base_o(rgn_base),
    .rgn_size_o(rgn_size), .rgn_en_o(rgn_en), .rgn_ap_o(rgn_ap), .rgn_xn_o(rgn_xn)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one access: driven at falling edge, sampled before the rising edge, released after it
  task automatic access(input logic [1:0] sel, input bit wr, input bit priv, input logic [31:0] wd,
                        output logic [31:0] rd, output logic und);
    @(negedge clk);
    acc_en = 1'b1; acc_wr = wr; acc_priv = priv; acc_sel = sel; acc_wdata = wd;
    #1;
    rd = acc_rdata; und = acc_undef;
    @(posedge clk);
    #1;
    acc_en = 1'b0; acc_wr = 1'b0; acc_wdata = 32'd0;
  endtask

  function automatic logic [31:0] pat_base(input int i);
    return 32'hA5C3_0F17 ^ (32'(i) * 32'h1357_9BDF);
  endfunction
  function automatic logic [31:0] pat_size(input int i);
    return 32'hFFFF_FFC0 | (32'((i + 4) % 32) << 1) | 32'(i % 2);
  endfunction
  function automatic logic [31:0] pat_acl(input int i);
    return ~(32'(i) * 32'h0101_0245);
  endfunction

  task automatic check_outputs(input string tag);
    for (int i = 0; i < N; i++) begin
      check(rgn_base[i*27 +: 27] == exp_base[i][31:5], tag, 64'(rgn_base[i*27 +: 27]), 64'(exp_base[i][31:5]));
      check(rgn_size[i*5 +: 5] == exp_size[i][5:1], tag, 64'(rgn_size[i*5 +: 5]), 64'(exp_size[i][5:1]));
      check(rgn_en[i] == exp_size[i][0], tag, 64'(rgn_en[i]), 64'(exp_size[i][0]));
      check(rgn_ap[i*3 +: 3] == exp_acl[i][10:8], tag, 64'(rgn_ap[i*3 +: 3]), 64'(exp_acl[i][10:8]));
      check(rgn_xn[i] == exp_acl[i][12], tag, 64'(rgn_xn[i]), 64'(exp_acl[i][12]));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic        und;
    for (int i = 0; i < N; i++) begin
      exp_base[i] = '0; exp_size[i] = '0; exp_acl[i] = '0;
    end
    repeat (3) @(posedge clk);
    #1;
    check(rgn_en == '0, "R6 enables after reset", 64'(rgn_en), 64'd0);
    @(negedge clk); rst_n = 1'b1;
    access(2'd0, 1'b0, 1'b1, 32'd0, rd, und);
    check(rd == 32'd0, "R6 index after reset", 64'(rd), 64'd0);
    access(2'd1, 1'b0, 1'b1, 32'd0, rd, und);
    check(rd == 32'd0, "R6 base after reset", 64'(rd), 64'd0);
    check_outputs("R6 fields after reset");

    // R1 R2 R3 R4 R5: sweep all regions with reserved bits set
    for (int i = 0; i < N; i++) begin
      access(2'd0, 1'b1, 1'b1, 32'hFFFF_FFF0 | 32'(i), rd, und);
      check(rd == 32'd0 && !und, "R9 write returns zero", 64'(rd), 64'd0);
      access(2'd0, 1'b0, 1'b1, 32'd0, rd, und);
      check(rd == 32'(i), "R1 index readback", 64'(rd), 64'(i));
      access(2'd1, 1'b1, 1'b1, pat_base(i), rd, und);
      access(2'd2, 1'b1, 1'b1, pat_size(i), rd, und);
      access(2'd3, 1'b1, 1'b1, pat_acl(i), rd, und);
      exp_base[i] = pat_base(i) & 32'hFFFF_FFE0;
      exp_size[i] = pat_size(i) & 32'h0000_003F;
      exp_acl[i]  = pat_acl(i)  & 32'h0000_173F;
    end
    check_outputs("R8 parallel outputs");

    for (int i = N - 1; i >= 0; i--) begin
      access(2'd0, 1'b1, 1'b1, 32'(i), rd, und);
      access(2'd1, 1'b0, 1'b1, 32'd0, rd, und);
      check(rd == exp_base[i], "R3 base readback", 64'(rd), 64'(exp_base[i]));
      access(2'd2, 1'b0, 1'b1, 32'd0, rd, und);
      check(rd == exp_size[i], "R4 size readback", 64'(rd), 64'(exp_size[i]));
      access(2'd3, 1'b0, 1'b1, 32'd0, rd, und);
      check(rd == exp_acl[i], "R5 acl readback", 64'(rd), 64'(exp_acl[i]));
    end

    // R7: unprivileged accesses with region 5 selected
    access(2'd0, 1'b1, 1'b1, 32'd5, rd, und);
    for (int s = 0; s < 4; s++) begin
      access(2'(s), 1'b1, 1'b0, 32'hFFFF_FFFF, rd, und);
      check(und == 1'b1, "R7 user write flagged", 64'(und), 64'd1);
      access(2'(s), 1'b0, 1'b0, 32'd0, rd, und);
      check(und == 1'b1 && rd == 32'd0, "R7 user read zero", 64'(rd), 64'd0);
    end
    check_outputs("R7 state unchanged");
    access(2'd0, 1'b0, 1'b1, 32'd0, rd, und);
    check(rd == 32'd5 && !und, "R7 index unchanged", 64'(rd), 64'd5);

    // R9: idle cycle
    @(negedge clk); acc_sel = 2'd3; acc_priv = 1'b1; #1;
    check(acc_rdata == 32'd0, "R9 idle read data", 64'(acc_rdata), 64'd0);

    // R2 R4 R8: flip one region's enable
    access(2'd0, 1'b1, 1'b1, 32'd3, rd, und);
    access(2'd2, 1'b1, 1'b1, 32'h0000_0014, rd, und);
    exp_size[3] = 32'h0000_0014;
    access(2'd2, 1'b1, 1'b1, 32'hFFFF_FF00, rd, und);
    exp_size[3] = 32'd0;
    check_outputs("R2 single region updated");
    access(2'd0, 1'b1, 1'b1, 32'd4, rd, und);
    access(2'd2, 1'b1, 1'b1, 32'h0000_0001, rd, und);
    exp_size[4] = 32'h0000_0001;
    check(rgn_en[4] == 1'b1, "R8 enable next cycle", 64'(rgn_en[4]), 64'd1);
    check(rgn_size[4*5 +: 5] == 5'd0, "R4 size code zero", 64'(rgn_size[4*5 +: 5]), 64'd0);

    // R6: second reset
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check(rgn_en == '0, "R6 enables cleared", 64'(rgn_en), 64'd0);
    rst_n = 1'b1;
    for (int i = 0; i < N; i++) begin
      exp_base[i] = '0; exp_size[i] = '0; exp_acl[i] = '0;
    end
    access(2'd0, 1'b0, 1'b1, 32'd0, rd, und);
    check(rd == 32'd0, "R6 index cleared", 64'(rd), 64'd0);
    check_outputs("R6 fields cleared");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule